// File: doc/BRIEF.md
# Dual-Channel PWM Output Stage

This block sits between a PWM time base and two output pins. It receives the raw compare-driven waveform and a brake-active flag, and turns them into two pin values. In independent mode both channels carry the same waveform. In complementary mode the second channel carries the inverse of the first, and an optional dead time delays the rising edge of each channel so that the pair never drives high together. The dead time can be stretched by a fixed prescale factor.

The level that reaches each pin is chosen in a fixed order. The brake action comes first, then the software mask, then the dead-time waveform. Polarity inversion is applied after that choice, and the output enable gate is applied last. Every path is registered once, so each pin settles one clock after the inputs that cause it.

Each channel has a dead-time state machine with three states:
- `DT_IDLE`: the raw waveform is low.
- `DT_COUNT`: the raw waveform is high and the dead time has not yet run out.
- `DT_PASS`: the rising edge has been released.

Transitions of the dead-time state machine:
- `DT_IDLE` to `DT_PASS`: the raw waveform goes high and the delay is zero, one, or bypassed.
- `DT_IDLE` to `DT_COUNT`: the raw waveform goes high and the delay is two or more.
- `DT_COUNT` to `DT_PASS`: the elapsed count reaches the target, or bypass becomes active.
- `DT_COUNT` or `DT_PASS` to `DT_IDLE`: the raw waveform goes low.

Top module: `pwm_out_stage`

## Requirements
- R1: While `rst_n` is low, both pins are 0.
- R2: With `comp_mode`=0, both pins follow `wave_in` one clock later, when enabled, not inverted, not masked and not braked.
- R3: With `comp_mode`=1 and dead time off, `pin_out[1]` is the inverse of `pin_out[0]`.
- R4: With `comp_mode`=1 and `dt_enable`=1, the rising edge of each channel is delayed by `dt_count` clocks. A falling edge passes with no added delay.
- R5: With `dt_presc_en`=1, each dead-time count lasts 2^`DT_PRESC_LOG2` clocks, which is 8 clocks by default.
- R6: With `comp_mode`=0, `dt_enable` and `dt_count` have no effect on the pins.
- R7: In `out_enable`, bit 0 gates CH0 and bit 1 gates CH1. A disabled pin is 0, whatever the inversion setting.
- R8: In `polarity_inv`, bit n inverts the selected level of channel n.
- R9: When `mask_en` bit n is 1, channel n takes `mask_level` bit n in place of the waveform, dead time included.
- R10: While `brake_active`=1, the 2-bit brake code overrides the mask. `brake_act`[1:0] applies to CH0 and [3:2] applies to CH1. The codes are: 0 gives the inverse of the held level, 1 gives the held level, 2 gives low and 3 gives high.
- R11: The held level is the channel's level before inversion in the last clock before the brake was sampled. It does not change while the brake stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wave_in | input | 1 | Raw waveform from the time base |
| brake_active | input | 1 | Brake is in force |
| comp_mode | input | 1 | 0 selects independent mode, 1 selects complementary mode |
| dt_enable | input | 1 | Enables dead-time insertion |
| dt_presc_en | input | 1 | Stretches each dead-time count by 2^DT_PRESC_LOG2 |
| dt_count | input | DT_W | Dead-time count |
| out_enable | input | 2 | Per-channel output enable |
| polarity_inv | input | 2 | Per-channel inversion |
| mask_en | input | 2 | Per-channel software mask enable |
| mask_level | input | 2 | Per-channel software mask level |
| brake_act | input | 4 | Per-channel brake code |
| pin_out | output | 2 | Pin values, bit 0 is CH0 |

## Verification
Without dead time, each pin is due exactly one clock after the inputs that decide it are sampled. With dead time, a rising edge is due `dt_count` clocks later, or `dt_count`·8 clocks later when prescaled. The bench computes the expected pin values at every rising edge and compares them half a period later, at the falling edge, when the registered outputs are stable. Directed measurements drive the waveform high at a falling edge and count the falling edges until the pin rises, so each measured dead time is compared with the programmed value plus the one-clock register latency.

// File: rtl/pwm_out_pkg.sv
package pwm_out_pkg;
    typedef enum logic [1:0] {
        BRK_TOGGLE = 2'd0,
        BRK_KEEP   = 2'd1,
        BRK_LOW    = 2'd2,
        BRK_HIGH   = 2'd3
    } brake_act_e;

    typedef enum logic [1:0] {
        DT_IDLE  = 2'd0,
        DT_COUNT = 2'd1,
        DT_PASS  = 2'd2
    } dt_state_e;
endpackage

// File: rtl/pwm_deadtime.sv
module pwm_deadtime
    import pwm_out_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic             bypass,
    input  logic [CNT_W-1:0] target,
    output logic             dt_out
);
    dt_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             no_delay;
    logic [CNT_W:0]   cnt_inc;

    assign no_delay = bypass || (target == '0);
    assign cnt_inc  = {1'b0, cnt_q} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DT_IDLE: begin
                cnt_d = '0;
                if (raw) begin
                    if (no_delay || target == CNT_W'(1)) begin
                        state_d = DT_PASS;
                    end else begin
                        state_d = DT_COUNT;
                        cnt_d   = CNT_W'(1);
                    end
                end
            end
            DT_COUNT: begin
                if (!raw) begin
                    state_d = DT_IDLE;
                    cnt_d   = '0;
                end else if (no_delay || cnt_inc >= {1'b0, target}) begin
                    state_d = DT_PASS;
                end else begin
                    cnt_d = cnt_inc[CNT_W-1:0];
                end
            end
            DT_PASS: begin
                if (!raw) state_d = DT_IDLE;
            end
            default: state_d = DT_IDLE;
        endcase
    end

    always_comb begin
        dt_out = raw && (no_delay || state_q == DT_PASS);
    end

    // R4: with a nonzero delay, the output never rises in the first clock of a raw pulse
    assert_dt_no_early_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_out && !no_delay) |-> $past(raw));
endmodule

// File: rtl/pwm_chan_mux.sv
module pwm_chan_mux
    import pwm_out_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dt_level,
    input  logic       brake,
    input  logic [1:0] brake_act,
    input  logic       mask_en,
    input  logic       mask_lvl,
    input  logic       pol_inv,
    input  logic       out_en,
    output logic       pin
);
    logic normal_lvl, sel_lvl, held_q;

    always_comb begin
        normal_lvl = mask_en ? mask_lvl : dt_level;
        sel_lvl    = normal_lvl;
        if (brake) begin
            unique case (brake_act_e'(brake_act))
                BRK_TOGGLE: sel_lvl = ~held_q;
                BRK_KEEP:   sel_lvl = held_q;
                BRK_LOW:    sel_lvl = 1'b0;
                BRK_HIGH:   sel_lvl = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            pin    <= 1'b0;
        end else begin
            if (!brake) held_q <= normal_lvl;
            pin <= (sel_lvl ^ pol_inv) & out_en;
        end
    end

    assert_disabled_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> !pin);
    assert_brake_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (brake && brake_act == 2'd2 && out_en && !pol_inv) |=> !pin);
    assert_brake_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (brake && brake_act == 2'd3 && out_en && !pol_inv) |=> pin);
    assert_brake_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (brake && $past(brake) && brake_act == 2'd1 && $past(brake_act) == 2'd1
         && $stable(pol_inv) && $stable(out_en)) |=> $stable(pin));
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
    import pwm_out_pkg::*;
#(
    parameter int DT_W          = 8,
    parameter int DT_PRESC_LOG2 = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wave_in,
    input  logic            brake_active,
    input  logic            comp_mode,
    input  logic            dt_enable,
    input  logic            dt_presc_en,
    input  logic [DT_W-1:0] dt_count,
    input  logic [1:0]      out_enable,
    input  logic [1:0]      polarity_inv,
    input  logic [1:0]      mask_en,
    input  logic [1:0]      mask_level,
    input  logic [3:0]      brake_act,
    output logic [1:0]      pin_out
);
    localparam int NCH   = 2;
    localparam int CNT_W = DT_W + DT_PRESC_LOG2;

    logic [NCH-1:0]   raw_wave, dt_wave;
    logic [CNT_W-1:0] dt_target;
    logic             dt_bypass;

    assign raw_wave[0] = wave_in;
    assign raw_wave[1] = comp_mode ? ~wave_in : wave_in;
    assign dt_bypass   = !comp_mode || !dt_enable;
    assign dt_target   = dt_presc_en ? (CNT_W'(dt_count) << DT_PRESC_LOG2)
                                     : CNT_W'(dt_count);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        pwm_deadtime #(.CNT_W(CNT_W)) u_dt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw    (raw_wave[ch]),
            .bypass (dt_bypass),
            .target (dt_target),
            .dt_out (dt_wave[ch])
        );
        pwm_chan_mux u_mux (
            .clk       (clk),
            .rst_n     (rst_n),
            .dt_level  (dt_wave[ch]),
            .brake     (brake_active),
            .brake_act (brake_act[2*ch +: 2]),
            .mask_en   (mask_en[ch]),
            .mask_lvl  (mask_level[ch]),
            .pol_inv   (polarity_inv[ch]),
            .out_en    (out_enable[ch]),
            .pin       (pin_out[ch])
        );
    end

    assert_comp_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_mode && !dt_enable && !brake_active && mask_en == 2'b00
         && out_enable == 2'b11 && polarity_inv == 2'b00) |=> (pin_out[0] != pin_out[1]));
    assert_indep_same_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!comp_mode && !brake_active && mask_en == 2'b00
         && out_enable == 2'b11 && polarity_inv == 2'b00) |=> (pin_out[0] == pin_out[1]));
endmodule

// File: tb/pwm_out_stage_tb_top.sv
module pwm_out_stage_tb_top;
    localparam int DW = 8;
    localparam int PS = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wave_in = 1'b0, brake_active = 1'b0, comp_mode = 1'b0;
    logic dt_enable = 1'b0, dt_presc_en = 1'b0;
    logic [DW-1:0] dt_count = '0;
    logic [1:0] out_enable = 2'b11, polarity_inv = 2'b00, mask_en = 2'b00, mask_level = 2'b00;
    logic [3:0] brake_act = 4'h0;
    logic [1:0] pin_out;

    int checks = 0, errors = 0;
    string cur_req = "R1";

    int run_m[2];
    bit passed_m[2], held_m[2], exp_m[2];

    always #10 clk = ~clk;

    pwm_out_stage #(.DT_W(DW), .DT_PRESC_LOG2(PS)) dut_i (
        .clk(clk), .rst_n(rst_n), .wave_in(wave_in), .brake_active(brake_active),
        .comp_mode(comp_mode), .dt_enable(dt_enable), .dt_presc_en(dt_presc_en),
        .dt_count(dt_count), .out_enable(out_enable), .polarity_inv(polarity_inv),
        .mask_en(mask_en), .mask_level(mask_level), .brake_act(brake_act), .pin_out(pin_out)
    );

    // Behavioural reference: evaluated at every rising edge from the sampled inputs
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                run_m[c] = 0; passed_m[c] = 0; held_m[c] = 0; exp_m[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                bit raw, zero, dtl, norm, lvl;
                int tgt, code;
                raw  = (c == 1 && comp_mode) ? !wave_in : wave_in;
                tgt  = dt_presc_en ? (int'(dt_count) * (1 << PS)) : int'(dt_count);
                zero = !comp_mode || !dt_enable || tgt == 0;
                dtl  = raw && (zero || passed_m[c]);
                norm = mask_en[c] ? mask_level[c] : dtl;
                code = int'(brake_act[2*c +: 2]);
                if (brake_active) begin
                    case (code)
                        0: lvl = !held_m[c];
                        1: lvl = held_m[c];
                        2: lvl = 0;
                        default: lvl = 1;
                    endcase
                end else begin
                    lvl = norm;
                    held_m[c] = norm;
                end
                exp_m[c]    = (lvl ^ polarity_inv[c]) & out_enable[c];
                passed_m[c] = raw && (passed_m[c] || zero || (run_m[c] + 1) >= tgt);
                run_m[c]    = raw ? run_m[c] + 1 : 0;
            end
        end
    end

    always @(negedge clk) begin
        for (int c = 0; c < 2; c++) begin
            checks++;
            if (pin_out[c] !== exp_m[c]) begin
                errors++;
                $display("FAIL %s ch%0d: pin=%b expected=%b at %0t", cur_req, c, pin_out[c], exp_m[c], $time);
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wave_run(input int hi, input int lo, input int reps);
        for (int r = 0; r < reps; r++) begin
            wave_in = 1'b1; cycles(hi);
            wave_in = 1'b0; cycles(lo);
        end
    endtask

    // Drive the waveform high and measure the clocks until CH0 rises, minus the register latency
    task automatic measure_rise(input int exp_delay, input string tag);
        int k;
        wave_in = 1'b0; cycles(4);
        wave_in = 1'b1; k = 0;
        do begin
            cycles(1); k++;
        end while (pin_out[0] !== 1'b1 && k < 400);
        checks++;
        if (k - 1 != exp_delay) begin
            errors++;
            $display("FAIL %s rise delay: actual=%0d expected=%0d", tag, k - 1, exp_delay);
        end
        cycles(exp_delay + 2);
        wave_in = 1'b0;
        cycles(1);
        checks++;
        if (pin_out[0] !== 1'b0) begin
            errors++;
            $display("FAIL %s fall delay: pin=%b expected=0", tag, pin_out[0]);
        end
        cycles(3);
    endtask

    initial begin
        cur_req = "R1";
        cycles(4);
        rst_n = 1'b1;
        cur_req = "R2";
        wave_run(3, 2, 4);
        wave_run(1, 1, 4);
        cur_req = "R6";
        dt_enable = 1'b1; dt_count = 8'd5;
        wave_run(4, 3, 3);
        measure_rise(0, "R6");
        cur_req = "R3";
        comp_mode = 1'b1; dt_enable = 1'b0;
        wave_run(3, 5, 3);
        cur_req = "R4";
        dt_enable = 1'b1; dt_count = 8'd3;
        wave_run(8, 8, 3);
        wave_run(2, 2, 3);
        measure_rise(3, "R4");
        cur_req = "R5";
        dt_presc_en = 1'b1; dt_count = 8'd2;
        wave_run(24, 24, 2);
        measure_rise(16, "R5");
        dt_presc_en = 1'b0; dt_count = 8'd1;
        cur_req = "R8";
        polarity_inv = 2'b10;
        wave_run(4, 4, 3);
        polarity_inv = 2'b11;
        wave_run(3, 3, 2);
        cur_req = "R7";
        out_enable = 2'b01;
        wave_run(4, 4, 2);
        out_enable = 2'b10;
        wave_run(4, 4, 2);
        out_enable = 2'b11; polarity_inv = 2'b00;
        cur_req = "R9";
        mask_en = 2'b01; mask_level = 2'b01;
        wave_run(5, 5, 2);
        mask_en = 2'b10; mask_level = 2'b00;
        wave_run(5, 5, 2);
        cur_req = "R10";
        mask_en = 2'b11; mask_level = 2'b10;
        brake_act = {2'd2, 2'd3};
        brake_active = 1'b1; wave_run(3, 3, 2);
        brake_act = {2'd3, 2'd2}; wave_run(3, 3, 2);
        brake_active = 1'b0; mask_en = 2'b00;
        wave_run(4, 4, 1);
        cur_req = "R11";
        wave_in = 1'b1; cycles(5);
        brake_act = {2'd1, 2'd0};
        brake_active = 1'b1; wave_run(2, 3, 3);
        brake_act = {2'd0, 2'd1}; cycles(4);
        brake_active = 1'b0; wave_run(3, 3, 2);
        comp_mode = 1'b0; wave_in = 1'b0; cycles(3);
        brake_active = 1'b1; cycles(4);
        brake_active = 1'b0; cycles(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired in %s", cur_req);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule